// File: doc/BRIEF.md
# Serial Controller Host Register Interface

This block is the 8-bit host-side front end of a serial controller. A host reaches it over a shared byte bus. The bus carries an active-low chip select, active-low read and write strobes, and a select line that picks command/status access or data access. Command-mode writes are routed into six configuration registers. Data-mode writes hand a byte to the transmit path. Command-mode reads return two status words in strict alternation. Data-mode reads return the byte offered by the receive path.

The code in the top two bits of a command byte picks its target register. One command can arm a second byte, so that the next command-mode write is stored as an address byte. The block tells the transmit and receive paths that configuration is complete once every one of the six registers has been written since reset. Data movement in either direction is suppressed until then. The serial datapath itself sits outside this block, behind plain ports.

Top module: `ser_host_if`

## Requirements
- R1: After reset all six command registers read zero, `configured_o` is low, and the first status read returns status word 1.
- R2: A write with `cs_ni` low and `cmd_sel_i` high takes effect on the clock edge that first sees `wr_ni` high after a low phase. Bits 7:6 select the register: 00 goes to reg 0, 01 to reg 1 and 10 to reg 2. For code 11, bit 5 low goes to reg 3 and bit 5 high goes to reg 5. The whole byte is stored.
- R3: A write or read strobe seen while `cs_ni` is high changes no register, produces no pulse and leaves `data_oe_o` low.
- R4: A write to reg 3 with bit 2 set arms address capture. The next command-mode write is stored verbatim in reg 4 whatever its top bits are, and capture is then disarmed.
- R5: Completed command-mode reads alternate between status word 1 and status word 2 and never repeat the same word twice in a row. Bit 7 of the returned byte is 0 for word 1 and 1 for word 2. Bits 6:0 come from `stat1_i` or `stat2_i` respectively.
- R6: A data-mode read returns `rx_data_i`. Its completion pulses `rx_pop_o` for one cycle only when `configured_o` is high.
- R7: A completed data-mode write presents the byte on `tx_data_o` and pulses `tx_push_o` for one cycle only when `configured_o` is high. Before that point the write is dropped.
- R8: `configured_o` rises once all six command registers have been written since reset, and it stays high until reset.
- R9: `data_oe_o` is high exactly while `cs_ni` and `rd_ni` are both low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cs_ni | input | 1 | Chip select, active low |
| cmd_sel_i | input | 1 | 1 = command/status access, 0 = data access |
| rd_ni | input | 1 | Read strobe, active low |
| wr_ni | input | 1 | Write strobe, active low |
| data_i | input | 8 | Bus byte from host |
| data_o | output | 8 | Bus byte to host |
| data_oe_o | output | 1 | Bus driver enable for the pad |
| stat1_i | input | 7 | Status word 1 payload |
| stat2_i | input | 7 | Status word 2 payload |
| rx_data_i | input | 8 | Byte offered by the receive path |
| rx_pop_o | output | 1 | One-cycle pulse: host consumed the receive byte |
| tx_data_o | output | 8 | Byte handed to the transmit path |
| tx_push_o | output | 1 | One-cycle pulse: transmit byte valid |
| cmd_regs_o | output | 48 | Six command registers, reg k at bits 8k+7:8k |
| configured_o | output | 1 | All command registers loaded since reset |

## Verification
A wrong status-word selector shows up on the second status read after reset, where bit 7 fails to flip. A stuck or lost address-capture state shows up on the write after the arming command: the byte lands in a decoded register instead of reg 4, or the reverse. A wrong loaded-mask bit shows up as a `configured_o` level that is wrong one cycle after the sixth distinct register write. It also shows up through push and pop pulses that appear or vanish on the next data access.

// File: rtl/ser_host_pkg.sv
package ser_host_pkg;
  localparam int unsigned DW   = 8;
  localparam int unsigned NCMD = 6;

  typedef enum logic [2:0] {
    REG_MODE  = 3'd0,
    REG_FMT   = 3'd1,
    REG_CTRL  = 3'd2,
    REG_OPT   = 3'd3,
    REG_ADDR  = 3'd4,
    REG_AUX   = 3'd5
  } cmd_id_e;

  localparam int unsigned ADDR_ARM_BIT = 2;
  localparam int unsigned SPLIT_BIT    = 5;
endpackage

// File: rtl/ser_host_strobe.sv
module ser_host_strobe #(
  parameter int unsigned NSTB = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            cs_ni,
  input  logic [NSTB-1:0] stb_ni,
  output logic [NSTB-1:0] done_o
);
  logic [NSTB-1:0] stb_q;

  for (genvar g = 0; g < NSTB; g++) begin : g_stb
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stb_q[g] <= 1'b1;
      else         stb_q[g] <= stb_ni[g];
    end
    // completion = strobe release while selected
    assign done_o[g] = stb_ni[g] & ~stb_q[g] & ~cs_ni;
  end
endmodule

// File: rtl/ser_host_cmd_regs.sv
module ser_host_cmd_regs
  import ser_host_pkg::*;
#(
  parameter int unsigned W = DW,
  parameter int unsigned N = NCMD
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_cmd_i,
  input  logic [W-1:0] din_i,
  output logic [N*W-1:0] regs_o,
  output logic         configured_o
);
  logic         arm_q;
  logic [N-1:0] loaded_q;
  logic [N-1:0] we;
  cmd_id_e      tgt;

  always_comb begin
    unique case (din_i[W-1 -: 2])
      2'b00:   tgt = REG_MODE;
      2'b01:   tgt = REG_FMT;
      2'b10:   tgt = REG_CTRL;
      default: tgt = din_i[SPLIT_BIT] ? REG_AUX : REG_OPT;
    endcase
    if (arm_q) tgt = REG_ADDR;
  end

  for (genvar k = 0; k < N; k++) begin : g_reg
    assign we[k] = wr_cmd_i && (int'(tgt) == k);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        regs_o[k*W +: W] <= '0;
        loaded_q[k]      <= 1'b0;
      end else if (we[k]) begin
        regs_o[k*W +: W] <= din_i;
        loaded_q[k]      <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       arm_q <= 1'b0;
    else if (wr_cmd_i) arm_q <= !arm_q && (tgt == REG_OPT) && din_i[ADDR_ARM_BIT];
  end

  assign configured_o = &loaded_q;

  a_r4_addr_capture: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_cmd_i && arm_q |=> regs_o[int'(REG_ADDR)*W +: W] == $past(din_i) && !arm_q);
  a_r2_route_mode: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_cmd_i && !arm_q && din_i[W-1 -: 2] == 2'b00 |=> regs_o[W-1:0] == $past(din_i));
  a_r8_cfg_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    configured_o |=> configured_o);
endmodule

// File: rtl/ser_host_status.sv
module ser_host_status
  import ser_host_pkg::*;
#(
  parameter int unsigned W = DW
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         stat_rd_i,
  input  logic [W-2:0] stat1_i,
  input  logic [W-2:0] stat2_i,
  output logic [W-1:0] stat_o
);
  logic sel_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        sel_q <= 1'b0;
    else if (stat_rd_i) sel_q <= ~sel_q;
  end

  assign stat_o = sel_q ? {1'b1, stat2_i} : {1'b0, stat1_i};

  a_r5_alternate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat_rd_i |=> sel_q != $past(sel_q));
endmodule

// File: rtl/ser_host_if.sv
module ser_host_if
  import ser_host_pkg::*;
#(
  parameter int unsigned W = DW,
  parameter int unsigned N = NCMD
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           cs_ni,
  input  logic           cmd_sel_i,
  input  logic           rd_ni,
  input  logic           wr_ni,
  input  logic [W-1:0]   data_i,
  output logic [W-1:0]   data_o,
  output logic           data_oe_o,
  input  logic [W-2:0]   stat1_i,
  input  logic [W-2:0]   stat2_i,
  input  logic [W-1:0]   rx_data_i,
  output logic           rx_pop_o,
  output logic [W-1:0]   tx_data_o,
  output logic           tx_push_o,
  output logic [N*W-1:0] cmd_regs_o,
  output logic           configured_o
);
  logic [1:0]   done;
  logic         wr_done, rd_done;
  logic [W-1:0] stat_byte;

  ser_host_strobe #(.NSTB(2)) u_stb (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .cs_ni  (cs_ni),
    .stb_ni ({rd_ni, wr_ni}),
    .done_o (done)
  );
  assign wr_done = done[0];
  assign rd_done = done[1];

  ser_host_cmd_regs #(.W(W), .N(N)) u_cmd (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .wr_cmd_i     (wr_done & cmd_sel_i),
    .din_i        (data_i),
    .regs_o       (cmd_regs_o),
    .configured_o (configured_o)
  );

  ser_host_status #(.W(W)) u_stat (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .stat_rd_i (rd_done & cmd_sel_i),
    .stat1_i   (stat1_i),
    .stat2_i   (stat2_i),
    .stat_o    (stat_byte)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_push_o <= 1'b0;
      tx_data_o <= '0;
      rx_pop_o  <= 1'b0;
    end else begin
      tx_push_o <= wr_done & ~cmd_sel_i & configured_o;
      rx_pop_o  <= rd_done & ~cmd_sel_i & configured_o;
      if (wr_done & ~cmd_sel_i & configured_o) tx_data_o <= data_i;
    end
  end

  assign data_oe_o = ~cs_ni & ~rd_ni;
  assign data_o    = cmd_sel_i ? stat_byte : rx_data_i;

  a_r7_push_needs_cfg: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_push_o |-> configured_o);
  a_r6_pop_needs_cfg: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_pop_o |-> configured_o);
  a_r6_pop_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_pop_o |=> !rx_pop_o);
endmodule

// File: tb/sim_ser_host_if.sv
module sim_ser_host_if;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cs_n = 1'b1, sel = 1'b0, rd_n = 1'b1, wr_n = 1'b1;
  logic [7:0]  din = '0, rx_data = 8'h00;
  logic [6:0]  s1 = 7'h2B, s2 = 7'h55;
  logic [7:0]  dout, tx_data;
  logic        oe, rx_pop, tx_push, cfg;
  logic [47:0] regs;
  int checks = 0, fails = 0;
  logic        push_seen, pop_seen;
  logic [7:0]  rd_val;

  always #4 clk = ~clk;

  ser_host_if u0 (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .cmd_sel_i(sel),
    .rd_ni(rd_n), .wr_ni(wr_n), .data_i(din), .data_o(dout), .data_oe_o(oe),
    .stat1_i(s1), .stat2_i(s2), .rx_data_i(rx_data), .rx_pop_o(rx_pop),
    .tx_data_o(tx_data), .tx_push_o(tx_push), .cmd_regs_o(regs), .configured_o(cfg)
  );

  // {byte, expected register index}
  localparam logic [10:0] VEC [8] = '{
    {8'h15, 3'd0}, {8'h4A, 3'd1}, {8'h83, 3'd2}, {8'hC0, 3'd3},
    {8'hE7, 3'd5}, {8'hC4, 3'd3}, {8'h3C, 3'd4}, {8'h2A, 3'd0}
  };

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic bus_wr(logic s, logic [7:0] d, logic cs_val = 1'b0);
    @(negedge clk); cs_n = cs_val; sel = s; din = d; wr_n = 1'b0;
    @(negedge clk); wr_n = 1'b1;
    @(negedge clk); push_seen = tx_push;
    cs_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic bus_rd(logic s);
    @(negedge clk); cs_n = 1'b0; sel = s; rd_n = 1'b0;
    @(negedge clk); rd_val = dout;
    chk("R9 oe during read", {7'd0, oe}, 8'd1);
    rd_n = 1'b1;
    @(negedge clk); pop_seen = rx_pop;
    cs_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog act=running exp=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    for (int k = 0; k < 6; k++) chk("R1 reg reset", regs[k*8 +: 8], 8'h00);
    chk("R1 cfg low", {7'd0, cfg}, 8'd0);
    chk("R9 oe idle", {7'd0, oe}, 8'd0);
    bus_rd(1'b1);
    chk("R1 first status word1", rd_val, 8'h2B);
    // R5 alternation
    bus_rd(1'b1);
    chk("R5 second is word2", rd_val, 8'hD5);
    s1 = 7'h11;
    bus_rd(1'b1);
    chk("R5 third is word1", rd_val, 8'h11);
    // R7 data write before configuration is dropped
    bus_wr(1'b0, 8'h99);
    chk("R7 no push unconfigured", {7'd0, push_seen}, 8'd0);
    rx_data = 8'h6E;
    bus_rd(1'b0);
    chk("R6 rx data returned", rd_val, 8'h6E);
    chk("R6 no pop unconfigured", {7'd0, pop_seen}, 8'd0);
    // R3 chip select high: write ignored, no drive
    bus_wr(1'b1, 8'h3F, 1'b1);
    chk("R3 write ignored cs high", regs[7:0], 8'h00);
    @(negedge clk); rd_n = 1'b0;
    @(negedge clk); chk("R3 no drive cs high", {7'd0, oe}, 8'd0);
    rd_n = 1'b1;
    @(negedge clk);
    // R2/R4 table walk
    for (int i = 0; i < 8; i++) begin
      bus_wr(1'b1, VEC[i][10:3]);
      chk(i == 6 ? "R4 addr byte" : "R2 route", regs[int'(VEC[i][2:0])*8 +: 8], VEC[i][10:3]);
      if (i == 4) chk("R8 cfg low with addr reg unloaded", {7'd0, cfg}, 8'd0);
    end
    chk("R4 reg0 untouched by addr byte", regs[7:0], 8'h2A);
    chk("R8 cfg high", {7'd0, cfg}, 8'd1);
    // R4 capture disarmed: next 00-code goes to reg 0
    bus_wr(1'b1, 8'h01);
    chk("R4 disarmed", regs[7:0], 8'h01);
    chk("R4 addr kept", regs[39:32], 8'h3C);
    // R7 push after configuration
    bus_wr(1'b0, 8'hA5);
    chk("R7 push", {7'd0, push_seen}, 8'd1);
    chk("R7 tx data", tx_data, 8'hA5);
    chk("R7 single pulse", {7'd0, tx_push}, 8'd0);
    bus_rd(1'b0);
    chk("R6 pop", {7'd0, pop_seen}, 8'd1);
    // status continues alternating: last status read was word1
    bus_rd(1'b1);
    chk("R5 word2 after data ops", rd_val, 8'hD5);
    // R1 reset again
    rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    chk("R1 cfg cleared", {7'd0, cfg}, 8'd0);
    chk("R1 reg cleared", regs[39:32], 8'h00);
    bus_rd(1'b1);
    chk("R1 status restarts word1", rd_val, 8'h11);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule